// File: doc/BRIEF.md
# Flash Status Register Responder

This block sits on the device side of an SPI link running in mode 0. It imitates the three-byte status register of a serial flash part. The first byte the host shifts in after chip select falls is taken as an opcode. That opcode is compared with three programmable read-status opcodes, and each of them is tied to one byte of the register. On a match, the chosen byte is shifted out on MISO, most significant bit first. The byte repeats for as long as the host keeps clocking. Two further programmable opcodes set and clear the write-enable latch bit. A busy-set pulse from the command-upload path sets the busy bit.

Software writes the whole register from the system clock domain. Each write passes through a small gray-coded asynchronous queue. Whenever SCK is active, the queue is drained into a staged copy of the register. The staged copy, which also carries the hardware changes to BUSY and WEL, is moved into the committed copy on the rising edge of chip select. Host reads and the software readback both show only the committed copy, so a host never sees a value that is half updated. The software readback is a two-flop synchronized copy of the committed register.

Top module: `flash_status_responder`

## Requirements
- R1: The block reset clears the staged and committed register to 000000h and holds MISO output enable low. A rising chip select does not clear the register.
- R2: An opcode equal to byte k of `cfgRdOps` (bits 8k+7..8k, k = 0, 1, 2) selects committed status byte k (bits 8k+7..8k). That byte is driven MSB first, with output enable high, from the SCK falling edge after the 8th rising edge. When several entries hold the same opcode, the lowest k wins.
- R3: If the host clocks past 8 data bits, the selected byte is sent again, MSB first, until chip select rises.
- R4: An opcode that matches none of the three read opcodes keeps `misoOe` low for the whole transaction.
- R5: Software writes are queued, drained into the staged copy on SCK rising edges, and committed when chip select rises. The queue holds 2^QUEUE_AW entries. A write presented while the queue is full is dropped.
- R6: WEL is bit 1 of byte 0. An opcode equal to `cfgWrenOp` sets it, and an opcode equal to `cfgWrdiOp` clears it. The change becomes visible after chip select rises.
- R7: BUSY is bit 0 of byte 0. A `busySet` high on an SCK rising edge sets it. A software write with bit 0 at 0 clears it, and a software write with bit 0 at 1 leaves it unchanged.
- R8: Software writes set or clear WEL and all other non-BUSY bits directly.
- R9: `statusReadback` follows the committed copy, never the staged copy. A write that has been applied during an open transaction is not visible until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the write port and the readback |
| rstN | input | 1 | Active-low asynchronous block reset |
| swWrValid | input | 1 | Software write strobe, one system clock per write |
| swWrData | input | 24 | Software write value for the whole register |
| statusReadback | output | 24 | Committed register synchronized to sysClk |
| sck | input | 1 | SPI clock from the host, mode 0 |
| csN | input | 1 | Active-low chip select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, valid while misoOe is high |
| misoOe | output | 1 | MISO output enable |
| busySet | input | 1 | Sets BUSY, sampled on SCK rising edges |
| cfgRdOps | input | 24 | Three read-status opcodes, byte k selects status byte k |
| cfgWrenOp | input | 8 | Write-enable opcode, typically 06h |
| cfgWrdiOp | input | 8 | Write-disable opcode, typically 04h |

## Verification
The bench builds the block with QUEUE_AW = 1, which gives a two-entry queue, and with BUSY at bit 0 and WEL at bit 1. With only two entries, three back-to-back software writes with SCK idle are enough to reach the full condition, so the dropped write becomes observable through the committed value. Setting all three read opcodes to one value exposes the index priority. Reading the readback mid-transaction separates the staged value from the committed value.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  localparam int STATUS_BYTES = 3;
  localparam int OP_W = 8;
  localparam int SEL_W = $clog2(STATUS_BYTES);
  localparam int REG_W = STATUS_BYTES * 8;

  typedef struct packed {
    logic             opDone;
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic             wren;
    logic             wrdi;
  } fsrStrobe_t;
endpackage

// File: rtl/fsr_wrq.sv
`timescale 1ns/1ps
module fsr_wrq #(
  parameter int DW = 24,
  parameter int AW = 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic          rdValid,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wBin, wGray, rBin, rGray;
  logic [PW-1:0] rGs1, rGs2, wGs1, wGs2;
  logic [PW-1:0] wBinNext, rBinNext;
  logic full, empty, push;

  assign full = (wBin - g2b(rGs2)) == DEPTH_P;
  assign empty = (rBin == g2b(wGs2));
  assign push = wrEn && !full;
  assign wBinNext = wBin + 1'b1;
  assign rBinNext = rBin + 1'b1;
  assign rdValid = !empty;
  assign rdData = mem[rBin[AW-1:0]];

  always_ff @(posedge wrClk) begin
    if (push) mem[wBin[AW-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin <= '0; wGray <= '0; rGs1 <= '0; rGs2 <= '0;
    end else begin
      rGs1 <= rGray;
      rGs2 <= rGs1;
      if (push) begin
        wBin <= wBinNext;
        wGray <= wBinNext ^ (wBinNext >> 1);
      end
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin <= '0; rGray <= '0; wGs1 <= '0; wGs2 <= '0;
    end else begin
      wGs1 <= wGray;
      wGs2 <= wGs1;
      if (!empty) begin
        rBin <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end
    end
  end

  // R5: a write offered while full leaves the write pointer where it was
  a_r5_drop_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && full) |=> $stable(wBin));
endmodule

// File: rtl/fsr_ctrl.sv
`timescale 1ns/1ps
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic                  sck,
  input  logic                  txnRst,
  input  logic                  mosi,
  input  logic [REG_W-1:0]      cfgRdOps,
  input  logic [OP_W-1:0]       cfgWrenOp,
  input  logic [OP_W-1:0]       cfgWrdiOp,
  output fsrStrobe_t            strobe,
  output logic                  opcodeDone
);
  localparam int CNT_W = $clog2(OP_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(OP_W);

  logic [CNT_W-1:0] bitCnt;
  logic [OP_W-1:0]  opShift;
  logic [OP_W-1:0]  fullOp;
  logic             anyHit;
  logic [SEL_W-1:0] hitSel;

  always_ff @(posedge sck or posedge txnRst) begin
    if (txnRst) begin
      bitCnt <= '0;
      opShift <= '0;
    end else if (bitCnt != DONE_CNT) begin
      bitCnt <= bitCnt + 1'b1;
      opShift <= fullOp;
    end
  end

  assign fullOp = {opShift[OP_W-2:0], mosi};
  assign opcodeDone = (bitCnt == DONE_CNT);

  always_comb begin
    anyHit = 1'b0;
    hitSel = '0;
    for (int k = STATUS_BYTES - 1; k >= 0; k--) begin
      if (fullOp == cfgRdOps[k*OP_W +: OP_W]) begin
        anyHit = 1'b1;
        hitSel = SEL_W'(k);
      end
    end
  end

  always_comb begin
    strobe.opDone = (bitCnt == LAST_BIT);
    strobe.hit    = strobe.opDone && anyHit;
    strobe.sel    = hitSel;
    strobe.wren   = strobe.opDone && (fullOp == cfgWrenOp);
    strobe.wrdi   = strobe.opDone && (fullOp == cfgWrdiOp);
  end

  // R2: the opcode decision is taken once per transaction
  a_r2_single_decode: assert property (@(posedge sck) disable iff (txnRst)
    strobe.opDone |=> !strobe.opDone);
endmodule

// File: rtl/fsr_dp.sv
`timescale 1ns/1ps
module fsr_dp
  import fsr_pkg::*;
#(
  parameter int BUSY_BIT = 0,
  parameter int WEL_BIT = 1
) (
  input  logic             sck,
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             txnRst,
  input  fsrStrobe_t       strobe,
  input  logic             opcodeDone,
  input  logic             busySet,
  input  logic             popValid,
  input  logic [REG_W-1:0] popData,
  output logic             miso,
  output logic             misoOe,
  output logic [REG_W-1:0] readback
);
  logic [REG_W-1:0] staged, stagedNext, committed;
  logic [REG_W-1:0] rbSync;
  logic [7:0]       txByte;
  logic [2:0]       txIdx;
  logic             active;

  always_comb begin
    stagedNext = staged;
    if (popValid) begin
      stagedNext = popData;
      stagedNext[BUSY_BIT] = staged[BUSY_BIT] & popData[BUSY_BIT];
    end
    if (busySet) stagedNext[BUSY_BIT] = 1'b1;
    if (strobe.wren) stagedNext[WEL_BIT] = 1'b1;
    if (strobe.wrdi) stagedNext[WEL_BIT] = 1'b0;
  end

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) staged <= '0;
    else staged <= stagedNext;
  end

  always_ff @(posedge csN or negedge rstN) begin
    if (!rstN) committed <= '0;
    else committed <= staged;
  end

  always_ff @(posedge sck or posedge txnRst) begin
    if (txnRst) begin
      active <= 1'b0;
      txByte <= '0;
      txIdx <= 3'd7;
    end else if (strobe.hit) begin
      active <= 1'b1;
      txByte <= committed[{strobe.sel, 3'b000} +: 8];
      txIdx <= 3'd7;
    end else if (active) begin
      txIdx <= txIdx - 1'b1;
    end
  end

  always_ff @(negedge sck or posedge txnRst) begin
    if (txnRst) begin
      miso <= 1'b0;
      misoOe <= 1'b0;
    end else begin
      miso <= txByte[txIdx];
      misoOe <= active;
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      rbSync <= '0;
      readback <= '0;
    end else begin
      rbSync <= committed;
      readback <= rbSync;
    end
  end

  // R7: BUSY in the staged copy only rises after a busy-set pulse
  a_r7_busy_rise_from_pulse: assert property (@(posedge sck) disable iff (!rstN)
    $rose(staged[BUSY_BIT]) |-> $past(busySet));
  // R6: WEL only rises from a write-enable opcode or a software write
  a_r6_wel_rise_cause: assert property (@(posedge sck) disable iff (!rstN)
    $rose(staged[WEL_BIT]) |-> ($past(strobe.wren) || $past(popValid && popData[WEL_BIT])));
  // R4: the output is only enabled once a full opcode has arrived
  a_r4_oe_after_opcode: assert property (@(posedge sck) disable iff (txnRst)
    misoOe |-> opcodeDone);
endmodule

// File: rtl/flash_status_responder.sv
`timescale 1ns/1ps
module flash_status_responder
  import fsr_pkg::*;
#(
  parameter int QUEUE_AW = 1,
  parameter int BUSY_BIT = 0,
  parameter int WEL_BIT = 1
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             swWrValid,
  input  logic [REG_W-1:0] swWrData,
  output logic [REG_W-1:0] statusReadback,
  input  logic             sck,
  input  logic             csN,
  input  logic             mosi,
  output logic             miso,
  output logic             misoOe,
  input  logic             busySet,
  input  logic [REG_W-1:0] cfgRdOps,
  input  logic [OP_W-1:0]  cfgWrenOp,
  input  logic [OP_W-1:0]  cfgWrdiOp
);
  logic             txnRst;
  logic             popValid;
  logic [REG_W-1:0] popData;
  logic             opcodeDone;
  fsrStrobe_t       strobe;

  assign txnRst = csN || !rstN;

  fsr_wrq #(.DW(REG_W), .AW(QUEUE_AW)) u_wrq (
    .wrClk(sysClk), .rdClk(sck), .rstN(rstN),
    .wrEn(swWrValid), .wrData(swWrData),
    .rdValid(popValid), .rdData(popData)
  );

  fsr_ctrl u_ctrl (
    .sck(sck), .txnRst(txnRst), .mosi(mosi),
    .cfgRdOps(cfgRdOps), .cfgWrenOp(cfgWrenOp), .cfgWrdiOp(cfgWrdiOp),
    .strobe(strobe), .opcodeDone(opcodeDone)
  );

  fsr_dp #(.BUSY_BIT(BUSY_BIT), .WEL_BIT(WEL_BIT)) u_dp (
    .sck(sck), .sysClk(sysClk), .rstN(rstN), .csN(csN), .txnRst(txnRst),
    .strobe(strobe), .opcodeDone(opcodeDone), .busySet(busySet),
    .popValid(popValid), .popData(popData),
    .miso(miso), .misoOe(misoOe), .readback(statusReadback)
  );
endmodule

// File: tb/flash_status_responder_tb.sv
`timescale 1ns/1ps
module flash_status_responder_tb;
  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrValid = 1'b0;
  logic [23:0] swWrData = '0;
  logic [23:0] statusReadback;
  logic        sck = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, misoOe;
  logic        busySet = 1'b0;
  logic [23:0] cfgRdOps = {8'h15, 8'h35, 8'h05};
  logic [7:0]  cfgWrenOp = 8'h06;
  logic [7:0]  cfgWrdiOp = 8'h04;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 sysClk = ~sysClk;

  flash_status_responder #(.QUEUE_AW(1), .BUSY_BIT(0), .WEL_BIT(1)) u_dut (
    .sysClk(sysClk), .rstN(rstN), .swWrValid(swWrValid), .swWrData(swWrData),
    .statusReadback(statusReadback), .sck(sck), .csN(csN), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .busySet(busySet), .cfgRdOps(cfgRdOps),
    .cfgWrenOp(cfgWrenOp), .cfgWrdiOp(cfgWrdiOp)
  );

  // opcode, bit count, expected data after the opcode, expected enable
  localparam logic [40:0] VEC [6] = '{
    {8'h05, 8'd24, 24'h00A2A2, 1'b1},
    {8'h35, 8'd16, 24'h00005A, 1'b1},
    {8'h15, 8'd16, 24'h0000C3, 1'b1},
    {8'h15, 8'd32, 24'hC3C3C3, 1'b1},
    {8'h35, 8'd12, 24'h000005, 1'b1},
    {8'hAB, 8'd16, 24'h000000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic swWrite(input logic [23:0] d);
    @(negedge sysClk);
    swWrValid = 1'b1;
    swWrData = d;
    @(negedge sysClk);
    swWrValid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge sysClk);
    #1;
  endtask

  task automatic csLow();
    csN = 1'b0;
    #20;
  endtask

  task automatic csHigh();
    #20 csN = 1'b1;
    #40;
  endtask

  task automatic shiftBits(input logic [7:0] op, input int nbits,
                           output logic [31:0] rx, output logic oeAny, output logic oeAll);
    rx = '0;
    oeAny = 1'b0;
    oeAll = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? op[7 - i] : 1'b0;
      #20 sck = 1'b1;
      #1;
      if (misoOe) oeAny = 1'b1;
      if (i >= 8) begin
        rx = {rx[30:0], miso};
        if (!misoOe) oeAll = 1'b0;
      end
      #19 sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] op, input int nbits,
                      output logic [31:0] rx, output logic oeAny, output logic oeAll);
    csLow();
    shiftBits(op, nbits, rx, oeAny, oeAll);
    csHigh();
  endtask

  initial begin
    logic [31:0] rx;
    logic oeAny, oeAll;
    repeat (4) @(posedge sysClk);
    @(negedge sysClk) rstN = 1'b1;
    settle();

    // R1: reset state
    chk("R1 readback after reset", statusReadback, 32'h0);
    chk("R1 output enable idle", misoOe, 1'b0);
    xfer(8'h05, 16, rx, oeAny, oeAll);
    chk("R1 host read after reset", rx, 32'h00);

    // R5 R8: software write reaches committed value after a transaction
    swWrite(24'hC35AA2);
    xfer(8'h00, 16, rx, oeAny, oeAll);
    settle();
    chk("R5 R8 committed after write", statusReadback, 32'hC35AA2);
    chk("R4 unmatched opcode no enable", oeAny, 1'b0);

    // R2 R3 R4: table of host reads
    foreach (VEC[v]) begin
      xfer(VEC[v][40:33], int'(VEC[v][32:25]), rx, oeAny, oeAll);
      if (VEC[v][0]) begin
        chk("R2 R3 read data", rx, {8'h00, VEC[v][24:1]});
        chk("R2 R3 enable through data", oeAll, 1'b1);
      end else begin
        chk("R4 no enable on unmatched", oeAny, 1'b0);
      end
    end
    chk("R1 register kept across transactions", statusReadback, 32'hC35AA2);

    // R9: staged value hidden until chip select rises
    swWrite(24'h0F0F00);
    csLow();
    shiftBits(8'h05, 16, rx, oeAny, oeAll);
    chk("R9 host read shows committed", rx, 32'hA2);
    settle();
    chk("R9 readback before commit", statusReadback, 32'hC35AA2);
    csHigh();
    settle();
    chk("R9 R8 readback after commit", statusReadback, 32'h0F0F00);

    // R6: write-enable and write-disable opcodes
    xfer(8'h06, 8, rx, oeAny, oeAll);
    settle();
    chk("R6 WEL set by opcode", statusReadback, 32'h0F0F02);
    xfer(8'h05, 16, rx, oeAny, oeAll);
    chk("R6 host sees WEL", rx, 32'h02);
    xfer(8'h04, 8, rx, oeAny, oeAll);
    settle();
    chk("R6 WEL cleared by opcode", statusReadback, 32'h0F0F00);

    // R7: BUSY set by pulse, software can only clear it
    busySet = 1'b1;
    xfer(8'h00, 8, rx, oeAny, oeAll);
    busySet = 1'b0;
    settle();
    chk("R7 BUSY set by pulse", statusReadback, 32'h0F0F01);
    xfer(8'h05, 16, rx, oeAny, oeAll);
    chk("R7 host sees BUSY", rx, 32'h01);
    swWrite(24'h1F0F01);
    xfer(8'h00, 16, rx, oeAny, oeAll);
    settle();
    chk("R7 writing one keeps BUSY", statusReadback, 32'h1F0F01);
    swWrite(24'h1F0F00);
    xfer(8'h00, 16, rx, oeAny, oeAll);
    settle();
    chk("R7 writing zero clears BUSY", statusReadback, 32'h1F0F00);
    swWrite(24'h000001);
    xfer(8'h00, 16, rx, oeAny, oeAll);
    settle();
    chk("R7 software cannot set BUSY", statusReadback, 32'h000000);

    // R5: third write with SCK idle is dropped
    swWrite(24'h111110);
    swWrite(24'h222220);
    swWrite(24'h333330);
    xfer(8'h00, 16, rx, oeAny, oeAll);
    settle();
    chk("R5 overflow write dropped", statusReadback, 32'h222220);

    // R2: lowest index wins when opcodes collide
    cfgRdOps = {8'h05, 8'h05, 8'h05};
    xfer(8'h05, 16, rx, oeAny, oeAll);
    chk("R2 lowest index priority", rx, 32'h20);
    cfgRdOps = {8'h15, 8'h35, 8'h05};
    xfer(8'h15, 16, rx, oeAny, oeAll);
    chk("R2 byte two after restore", rx, 32'h22);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule